// File: doc/BRIEF.md
# Victim Writeback Acceptance Controller

This block tracks the coherence state of one line in a shared second-level cache. It takes victim writebacks that upper-level caches send when they evict a line. A writeback request names its kind (dirty or clean), a shared hint and the requester. The controller accepts the request only while the line sits in a stable state (I, S, E, O, M). It sends an acknowledgement to the requester on the next cycle, before any data has been seen. It then waits in a transient state until the response channel brings either the data message or a stale notification.

When the wait ends, the controller picks the final state. That choice uses the state held before the writeback, the writeback kind and the shared flag carried on the data. On data it writes the line; on a stale notification it does not. It then sends the directory one unblock message. A request that arrives while the line is waiting is refused with a same-cycle retry. A response that arrives while the line is stable is consumed and changes nothing.

The states are named as follows. The stable states are I, S, E, O and M. A transient state is written W(prior, kind), where prior is the stable state held before the writeback and kind is the writeback kind. There are three kinds of transition:
- Accept: a stable state goes to W(prior, kind) on a request.
- Complete: W goes to its final stable state on data.
- Stale-return: W goes back to its prior state, or to I, on a stale notification.

Top module: `vwb_line_ctrl`

## Requirements
- R1: After reset the line reads state I (line_state code I=0, S=1, E=2, O=3, M=4), line_busy, ack_valid, unb_valid and line_dirty are all 0, and line_data is 0.
- R2: A request seen while line_busy is 0 is accepted. On the next cycle ack_valid is 1 for exactly one cycle, ack_dst equals the requester, and line_busy is 1 while line_state still shows the prior state. req_kind bit 1 marks the writeback dirty and bit 0 carries the shared hint.
- R3: On the data message of a dirty writeback, the final state is O if the shared hint or the data's shared flag is set, and M otherwise. An owner unblock is sent.
- R4: On the data message of a clean writeback, a prior state of M or O is kept. A prior state of S stays S. A prior state of I or E becomes S when the data's shared flag is set and E otherwise. The unblock is a sharer unblock for S and an owner unblock for any other final state.
- R5: A stale notification that ends a writeback begun from I returns the line to I. It frees the line, which clears line_data to 0 and line_dirty to 0, and sends a not-valid unblock.
- R6: A stale notification with a prior state of S, E, O or M returns the line to that prior state without writing data. It sends a sharer unblock for S and an owner unblock otherwise. The unblock bits are (unb_owner, unb_live): owner=(1,1), sharer=(0,1), not-valid=(0,0).
- R7: A completing data message writes rsp_data into line_data. line_dirty is set when rsp_dirty is 1 and is never cleared by a clean data message.
- R8: A response seen while line_busy is 0 is consumed with no effect: no unblock, and no change to state, data or dirty bit.
- R9: A request seen while line_busy is 1 raises req_retry in the same cycle. It produces no acknowledgement and leaves the state and the saved writeback unchanged.
- R10: Unblock and state update appear together on the cycle after the completing response. unb_valid is 1 for exactly one cycle and line_busy returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Writeback request present |
| req_kind | input | 2 | Bit 1 dirty, bit 0 shared hint |
| req_src | input | SRC_W | Requester identity |
| req_retry | output | 1 | Request refused, line is waiting |
| ack_valid | output | 1 | Writeback acknowledgement pulse |
| ack_dst | output | SRC_W | Destination of the acknowledgement |
| rsp_valid | input | 1 | Response message present |
| rsp_stale | input | 1 | Response is a stale notification |
| rsp_shared | input | 1 | Shared flag on the data |
| rsp_dirty | input | 1 | Dirty mark on the data |
| rsp_data | input | DATA_W | Data payload |
| unb_valid | output | 1 | Unblock message pulse |
| unb_owner | output | 1 | Unblock owner bit |
| unb_live | output | 1 | Unblock valid-copy bit |
| line_state | output | 3 | Stable or prior state code |
| line_busy | output | 1 | Line is in a transient state |
| line_dirty | output | 1 | Line dirty bit |
| line_data | output | DATA_W | Line contents |

## Verification
Several internal faults show up within one cycle of the completing response. A corrupted prior state or saved kind appears as a wrong line_state or a wrong unblock code at that point. A lost saved requester appears on ack_dst in the cycle right after acceptance. A wrong phase appears at once as a retry that should not be there, a missing acknowledgement, or an unblock raised by a response that came while the line was stable. Dirty-bit faults stay hidden until a later clean data message should have left the bit set. For that reason the stimulus repeats writebacks onto lines that already hold data.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

    typedef enum logic [2:0] {
        LS_I = 3'd0,
        LS_S = 3'd1,
        LS_E = 3'd2,
        LS_O = 3'd3,
        LS_M = 3'd4
    } line_st_e;

    typedef enum logic {
        PH_STABLE = 1'b0,
        PH_WAIT   = 1'b1
    } phase_e;

    typedef struct packed {
        logic dirty;
        logic shared;
    } wb_kind_t;

    typedef struct packed {
        logic owner;
        logic live;
    } unb_code_t;

    localparam unb_code_t UB_OWNER  = '{owner: 1'b1, live: 1'b1};
    localparam unb_code_t UB_SHARER = '{owner: 1'b0, live: 1'b1};
    localparam unb_code_t UB_NONE   = '{owner: 1'b0, live: 1'b0};

endpackage

// File: rtl/vwb_resolve.sv
module vwb_resolve
    import vwb_pkg::*;
(
    input  line_st_e  prior,
    input  wb_kind_t  kind,
    input  logic      stale,
    input  logic      data_shared,
    output line_st_e  final_st,
    output unb_code_t code,
    output logic      free_line
);

    always_comb begin
        free_line = 1'b0;
        if (stale) begin
            final_st  = prior;
            free_line = (prior == LS_I);
        end else if (kind.dirty) begin
            final_st = (kind.shared || data_shared) ? LS_O : LS_M;
        end else begin
            unique case (prior)
                LS_M, LS_O: final_st = prior;
                LS_S:       final_st = LS_S;
                LS_E, LS_I: final_st = data_shared ? LS_S : LS_E;
                default:    final_st = LS_I;
            endcase
        end

        if (free_line)
            code = UB_NONE;
        else if (final_st == LS_S)
            code = UB_SHARER;
        else
            code = UB_OWNER;
    end

endmodule

// File: rtl/vwb_line_store.sv
module vwb_line_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              set_dirty,
    input  logic              clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data,
    output logic              dirty
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data  <= '0;
            dirty <= 1'b0;
        end else if (wr) begin
            data <= wdata;
            if (set_dirty)
                dirty <= 1'b1;
        end
    end

    // R7: only a free may drop the dirty bit
    a_r7_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dirty && !clr |=> dirty);

endmodule

// File: rtl/vwb_line_ctrl.sv
module vwb_line_ctrl
    import vwb_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [SRC_W-1:0]  req_src,
    output logic              req_retry,
    output logic              ack_valid,
    output logic [SRC_W-1:0]  ack_dst,
    input  logic              rsp_valid,
    input  logic              rsp_stale,
    input  logic              rsp_shared,
    input  logic              rsp_dirty,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              unb_valid,
    output logic              unb_owner,
    output logic              unb_live,
    output logic [2:0]        line_state,
    output logic              line_busy,
    output logic              line_dirty,
    output logic [DATA_W-1:0] line_data
);

    phase_e           phase_q;
    line_st_e         st_q;
    wb_kind_t         kind_q;
    logic [SRC_W-1:0] src_q;
    logic             ack_q;
    logic             unb_q;
    unb_code_t        unb_code_q;

    line_st_e  res_st;
    unb_code_t res_code;
    logic      res_free;

    logic accept;
    logic complete;

    assign accept   = req_valid && (phase_q == PH_STABLE);
    assign complete = rsp_valid && (phase_q == PH_WAIT);

    vwb_resolve u_resolve (
        .prior       (st_q),
        .kind        (kind_q),
        .stale       (rsp_stale),
        .data_shared (rsp_shared),
        .final_st    (res_st),
        .code        (res_code),
        .free_line   (res_free)
    );

    vwb_line_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (complete && !rsp_stale),
        .set_dirty (rsp_dirty),
        .clr       (complete && res_free),
        .wdata     (rsp_data),
        .data      (line_data),
        .dirty     (line_dirty)
    );

    // state register: phase, stable/prior state, saved writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STABLE;
            st_q    <= LS_I;
            kind_q  <= '0;
            src_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_STABLE: begin
                    if (accept) begin
                        phase_q <= PH_WAIT;
                        kind_q  <= wb_kind_t'(req_kind);
                        src_q   <= req_src;
                    end
                end
                PH_WAIT: begin
                    if (complete) begin
                        phase_q <= PH_STABLE;
                        st_q    <= res_st;
                    end
                end
                default: phase_q <= PH_STABLE;
            endcase
        end
    end

    // output register: acknowledgement and unblock pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q      <= 1'b0;
            unb_q      <= 1'b0;
            unb_code_q <= UB_NONE;
        end else begin
            ack_q <= accept;
            unb_q <= complete;
            if (complete)
                unb_code_q <= res_code;
        end
    end

    assign req_retry  = req_valid && (phase_q == PH_WAIT);
    assign ack_valid  = ack_q;
    assign ack_dst    = src_q;
    assign unb_valid  = unb_q;
    assign unb_owner  = unb_code_q.owner;
    assign unb_live   = unb_code_q.live;
    assign line_state = st_q;
    assign line_busy  = (phase_q == PH_WAIT);

    // R2: accepted request is acknowledged to its requester next cycle
    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_retry |=> ack_valid && ack_dst == $past(req_src) && line_busy);

    // R9: a refused request never yields an acknowledgement
    a_r9_no_ack_on_retry: assert property (@(posedge clk) disable iff (!rst_n)
        req_retry |=> !ack_valid && $stable(ack_dst));

    // R6: owner without a valid copy is not a legal unblock
    a_r6_unblock_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        unb_valid |-> (unb_live || !unb_owner));

    // R5: a not-valid unblock comes with a freed line
    a_r5_notvalid_frees: assert property (@(posedge clk) disable iff (!rst_n)
        unb_valid && !unb_live |-> line_state == LS_I && !line_dirty);

    // R8: responses to a stable line leave no trace
    a_r8_stable_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !line_busy |=> !unb_valid && $stable(line_data));

    // R10: completion returns the line to a stable state with an unblock
    a_r10_unblock_with_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && line_busy |=> unb_valid && !line_busy);

endmodule

// File: tb/sim_vwb_line_ctrl.sv
module sim_vwb_line_ctrl;

    localparam int SRC_W  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [1:0]        req_kind;
    logic [SRC_W-1:0]  req_src;
    logic              req_retry;
    logic              ack_valid;
    logic [SRC_W-1:0]  ack_dst;
    logic              rsp_valid, rsp_stale, rsp_shared, rsp_dirty;
    logic [DATA_W-1:0] rsp_data;
    logic              unb_valid, unb_owner, unb_live;
    logic [2:0]        line_state;
    logic              line_busy, line_dirty;
    logic [DATA_W-1:0] line_data;

    int checks = 0;
    int errors = 0;

    // reference model
    int  m_st;
    bit  m_busy;
    bit  m_kd, m_ks;
    int  m_src;
    bit  m_dirty;
    int unsigned m_data;

    always #5 clk = ~clk;

    vwb_line_ctrl #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src),
        .req_retry(req_retry), .ack_valid(ack_valid), .ack_dst(ack_dst),
        .rsp_valid(rsp_valid), .rsp_stale(rsp_stale), .rsp_shared(rsp_shared),
        .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .unb_valid(unb_valid), .unb_owner(unb_owner), .unb_live(unb_live),
        .line_state(line_state), .line_busy(line_busy),
        .line_dirty(line_dirty), .line_data(line_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_final(int prior, bit kd, bit ks, bit stale, bit dsh);
        if (stale) return prior;
        if (kd) return (ks || dsh) ? 3 : 4;
        if (prior == 4 || prior == 3) return prior;
        if (prior == 1) return 1;
        return dsh ? 1 : 2;
    endfunction

    // unblock code as {owner, live}
    function automatic int exp_code(int prior, bit stale, int fin);
        if (stale && prior == 0) return 0;
        if (fin == 1) return 1;
        return 3;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 0; req_kind = 0; req_src = 0;
        rsp_valid = 0; rsp_stale = 0; rsp_shared = 0; rsp_dirty = 0; rsp_data = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_busy = 0; m_kd = 0; m_ks = 0; m_src = 0; m_dirty = 0; m_data = 0;
        #1;
        chk(line_state == 3'd0, "R1 state", line_state, 0);
        chk(!line_busy && !ack_valid && !unb_valid, "R1 flags",
            {line_busy, ack_valid, unb_valid}, 0);
        chk(!line_dirty && line_data == '0, "R1 line", line_data, 0);
    endtask

    // one cycle: drive at negedge, check retry, check registered results next negedge
    task automatic step(input bit rv, input bit [1:0] kind, input int src,
                        input bit sv, input bit stl, input bit sh, input bit dt,
                        input int unsigned dat);
        bit    e_ack, e_unb;
        int    e_fin, e_code;
        string tg;
        req_valid = rv; req_kind = kind; req_src = src[SRC_W-1:0];
        rsp_valid = sv; rsp_stale = stl; rsp_shared = sh; rsp_dirty = dt; rsp_data = dat;
        #1;
        chk(req_retry == (rv && m_busy), "R9 retry", req_retry, rv && m_busy);
        e_ack = rv && !m_busy;
        e_unb = sv && m_busy;
        e_fin = exp_final(m_st, m_kd, m_ks, stl, sh);
        e_code = exp_code(m_st, stl, e_fin);
        if (e_unb) begin
            if (stl && m_st == 0)      tg = "R5";
            else if (stl)              tg = "R6";
            else if (m_kd)             tg = "R3";
            else                       tg = "R4";
        end else if (sv)               tg = "R8";
        else if (rv && m_busy)         tg = "R9";
        else                           tg = "R2";
        // model update
        if (e_ack) begin
            m_busy = 1; m_kd = kind[1]; m_ks = kind[0]; m_src = src;
        end else if (e_unb) begin
            m_busy = 0;
            if (stl && m_st == 0) begin
                m_data = 0; m_dirty = 0;
            end else if (!stl) begin
                m_data = dat;
                if (dt) m_dirty = 1;
            end
            m_st = e_fin;
        end
        @(negedge clk);
        chk(ack_valid == e_ack, {tg, " ack"}, ack_valid, e_ack);
        if (e_ack) chk(ack_dst == m_src[SRC_W-1:0], "R2 ack_dst", ack_dst, m_src);
        chk(unb_valid == e_unb, {tg, " R10 unblock"}, unb_valid, e_unb);
        if (e_unb) chk({unb_owner, unb_live} == e_code[1:0], {tg, " code"},
                       {unb_owner, unb_live}, e_code);
        chk(line_state == m_st[2:0], {tg, " state"}, line_state, m_st);
        chk(line_busy == m_busy, {tg, " busy"}, line_busy, m_busy);
        chk(line_dirty == m_dirty, {tg, " R7 dirty"}, line_dirty, m_dirty);
        chk(line_data == m_data, {tg, " R7 data"}, line_data, m_data);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();
        // R2/R3: dirty writeback from I, unshared dirty data -> M
        step(1, 2'b10, 3, 0, 0, 0, 0, 0);
        step(1, 2'b00, 5, 0, 0, 0, 0, 0);          // R9 retry while waiting
        step(0, 0, 0, 1, 0, 0, 1, 32'hA5A5_0001);  // -> M owner, dirty
        step(0, 0, 0, 1, 0, 1, 0, 32'hDEAD_BEEF);  // R8 stable response ignored
        // R4/R7: clean writeback on M keeps M and dirty bit
        step(1, 2'b00, 7, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 32'h0000_1234);
        // R6: stale on M returns to M
        step(1, 2'b11, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 32'hFFFF_FFFF);
        // R5: stale from I frees line
        do_reset();
        step(1, 2'b00, 9, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 32'h1111_1111);
        // R4: clean with shared data from I -> S sharer
        step(1, 2'b01, 4, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 1, 0, 32'h2222_2222);
        // R6: stale on S -> S sharer
        step(1, 2'b00, 6, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 1, 32'h3333_3333);
        // R3: dirty-shared hint on S -> O owner
        step(1, 2'b11, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 1, 32'h4444_4444);
        // R4: clean on I -> E owner
        do_reset();
        step(1, 2'b00, 8, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 32'h5555_5555);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 96) do_reset();
            step(($urandom % 3) != 0, 2'($urandom), int'($urandom % 16),
                 ($urandom % 3) == 0, ($urandom % 4) == 0, 1'($urandom),
                 1'($urandom), $urandom);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule